// File: doc/BRIEF.md
# Multiple-Time-Programmable Code Memory Mode Controller

This block sits between the external programming pins of a chip and its on-chip rewritable code store. It turns the pins into an operating mode and carries that mode out on a behavioural byte array. The pins are chip enable, output enable, a two-bit encoded programming-voltage level, a 16-bit address and an 8-bit data input. The modes are read, output disable, byte program, program verify, bulk erase and erase verify. Cell physics and the analog high-voltage supply are not modelled; the voltage level arrives already encoded.

Bits can only be cleared: a program merges the new byte into the old one with a bitwise AND, and only a bulk erase sets cells back to 1. An 8-bit security register sits beside the array. Its bit 0 is a lock, and while the lock is programmed low, array reads return a blank value. Program and erase fire once, on the cycle the mode is entered, so a pin combination that is held does not repeat the operation. A programming flow writes a byte and then reads it back in program verify mode. An erase flow erases the array and then reads it back in erase verify mode.

Top module: `mtp_prog_ctrl`

## Requirements
- R1: Synchronous active-low reset gives these values at the outputs: `dout_en`=0, `dout`=0x00 and `mode_o`=0 (idle). Every array byte and the security register are reset to 0xFF.
- R2: The decoded mode appears on `mode_o` one clock after the pins are sampled. The voltage codes are 0=normal, 1=program level, 2=erase level and 3=reserved. The mode codes and their pin combinations are:
    - idle, code 0: every combination not listed below.
    - read, code 1: normal, `ce_n`=0, `oe_n`=0.
    - output disable, code 2: normal, `oe_n`=1.
    - program, code 3: program level, `ce_n`=0, `oe_n`=1.
    - program verify, code 4: program level, `ce_n`=1, `oe_n`=0.
    - erase, code 5: erase level, `ce_n`=0, `oe_n`=1.
    - erase verify, code 6: erase level, `ce_n`=1, `oe_n`=0.
- R3: When `oe_n` was high at the sampling edge, the next cycle has `dout_en`=0 and `dout`=0x00.
- R4: Read, program verify and erase verify drive `dout` with `dout_en`=1, one clock after sampling. With address bit 15 clear, the value is the array byte at the address. With bit 15 set, the value is the security register. An address with bit 15 clear that lies at or above the array depth (default 256) reads 0xFF and is never written.
- R5: On entry into program mode, the addressed byte (or the security register, when address bit 15 is set) is replaced by its old value AND `din`. This happens once per entry, even if `din` changes while the mode is held.
- R6: A program never sets a bit that is already 0. For example, 0x3C programmed onto 0xF0 leaves 0x30.
- R7: On entry into erase mode, every array byte and the security register become 0xFF. Erase is the only way a stored 0 returns to 1.
- R8: While security bit 0 is 0 (locked), array reads in any read-type mode return 0xFF. Security register reads still return the real value.
- R9: A program verify right after a program returns the merged byte.
- R10: Idle combinations drive nothing and leave the array and the security register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Byte address; bit 15 selects the security register |
| din | input | 8 | Data to program |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vlvl | input | 2 | Encoded programming voltage: 0 normal, 1 program, 2 erase, 3 reserved |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_en | output | 1 | Read data is being driven |
| mode_o | output | 3 | Registered mode code |

## Verification
The assertions assume that the pins are stable around the sampling edge and that address bit 15 alone separates security access from array access. The bench changes every pin only on the falling clock edge, so each vector is sampled once and unambiguously. The lock and monotonic-clearing properties compare values across one edge, so they also assume that reset is held for at least one full clock. The bench starts with several reset cycles and holds its later reset for exactly one clock.

// File: rtl/mtp_prog_pkg.sv
// Shared types for the code-memory mode controller.
// Assumes byte-wide storage and a lock flag inside the security register.
package mtp_prog_pkg;
    localparam int BYTE_W   = 8;
    localparam int LOCK_BIT = 0;

    typedef enum logic [1:0] {
        VL_NORM  = 2'd0,
        VL_PROG  = 2'd1,
        VL_ERASE = 2'd2,
        VL_RSVD  = 2'd3
    } vlvl_e;

    typedef enum logic [2:0] {
        MD_IDLE   = 3'd0,
        MD_READ   = 3'd1,
        MD_OUTDIS = 3'd2,
        MD_PROG   = 3'd3,
        MD_PVER   = 3'd4,
        MD_ERASE  = 3'd5,
        MD_EVER   = 3'd6
    } mtp_mode_e;
endpackage

// File: rtl/mtp_mode_decode.sv
// Pin decoder and mode register.
// Turns the voltage level, ce_n and oe_n into a mode, holds the mode of the
// previous cycle, and produces one-cycle strobes on entry into program or
// erase mode. Assumes the pins are synchronous to clk.
module mtp_mode_decode
    import mtp_prog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] vlvl,
    input  logic      ce_n,
    input  logic      oe_n,
    output mtp_mode_e mode_now,
    output mtp_mode_e mode_q,
    output logic      prog_stb,
    output logic      erase_stb
);
    // Combinational pin-to-mode table; unlisted combinations fall to idle.
    always_comb begin
        mode_now = MD_IDLE;
        case (vlvl)
            VL_NORM: begin
                if (oe_n)       mode_now = MD_OUTDIS;
                else if (!ce_n) mode_now = MD_READ;
            end
            VL_PROG: begin
                if (!ce_n && oe_n)      mode_now = MD_PROG;
                else if (ce_n && !oe_n) mode_now = MD_PVER;
            end
            VL_ERASE: begin
                if (!ce_n && oe_n)      mode_now = MD_ERASE;
                else if (ce_n && !oe_n) mode_now = MD_EVER;
            end
            default: mode_now = MD_IDLE;
        endcase
    end

    // Holds the mode seen at the previous edge, for edge detection and status.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_IDLE;
        else        mode_q <= mode_now;
    end

    assign prog_stb  = (mode_now == MD_PROG)  && (mode_q != MD_PROG);
    assign erase_stb = (mode_now == MD_ERASE) && (mode_q != MD_ERASE);
endmodule

// File: rtl/mtp_cell_array.sv
// Behavioural cell array plus security register.
// Programming ANDs the data into one byte; erase sets everything to 0xFF.
// Addresses at or above DEPTH match no row, read 0xFF and are never written.
// Assumes DEPTH fits in the address bits below the security-select bit.
module mtp_cell_array
    import mtp_prog_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_stb,
    input  logic              erase_stb,
    input  logic              sec_sel,
    input  logic [ADDR_W-2:0] row_addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] sec_q
);
    localparam int RA_W = ADDR_W - 1;
    localparam logic [BYTE_W-1:0] ERASED = {BYTE_W{1'b1}};

    logic [DEPTH-1:0]  row_hit;
    logic [BYTE_W-1:0] mem_q [DEPTH];

    // One address comparator per row.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign row_hit[g] = (row_addr == RA_W'(g));
    end

    // Storage update: reset and erase fill with ones, program clears bits only.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_stb) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
            sec_q <= ERASED;
        end else if (prog_stb) begin
            if (sec_sel) begin
                sec_q <= sec_q & wdata;
            end else begin
                for (int i = 0; i < DEPTH; i++)
                    if (row_hit[i]) mem_q[i] <= mem_q[i] & wdata;
            end
        end
    end

    // Read multiplexer; no matching row yields the erased value.
    always_comb begin
        rd_byte = ERASED;
        for (int i = 0; i < DEPTH; i++)
            if (row_hit[i]) rd_byte = mem_q[i];
    end
endmodule

// File: rtl/mtp_read_path.sv
// Registered output stage.
// Drives data only in read-type modes, blanks array data while locked,
// and returns zero when not driving. Assumes sec_q bit LOCK_BIT low = locked.
module mtp_read_path
    import mtp_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mtp_mode_e         mode_now,
    input  logic              sec_sel,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [BYTE_W-1:0] sec_q,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en
);
    logic              rd_mode;
    logic              locked;
    logic [BYTE_W-1:0] sel_val;

    // Choose the byte a read-type mode would present.
    always_comb begin
        rd_mode = (mode_now == MD_READ) || (mode_now == MD_PVER) ||
                  (mode_now == MD_EVER);
        locked  = !sec_q[LOCK_BIT];
        if (sec_sel)     sel_val = sec_q;
        else if (locked) sel_val = {BYTE_W{1'b1}};
        else             sel_val = rd_byte;
    end

    // Register the output and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_mode;
            dout    <= rd_mode ? sel_val : '0;
        end
    end
endmodule

// File: rtl/mtp_prog_ctrl.sv
// Top of the code-memory mode controller.
// Connects the pin decoder, the cell array and the output stage.
// Address bit ADDR_W-1 selects the security register; the rest index rows.
module mtp_prog_ctrl
    import mtp_prog_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [1:0]        vlvl,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic [2:0]        mode_o
);
    mtp_mode_e         mode_now;
    mtp_mode_e         mode_q;
    logic              prog_stb;
    logic              erase_stb;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] sec_q;
    logic              sec_sel;

    assign sec_sel = addr[ADDR_W-1];
    assign mode_o  = mode_q;

    mtp_mode_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .vlvl      (vlvl),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .mode_now  (mode_now),
        .mode_q    (mode_q),
        .prog_stb  (prog_stb),
        .erase_stb (erase_stb)
    );

    mtp_cell_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_stb  (prog_stb),
        .erase_stb (erase_stb),
        .sec_sel   (sec_sel),
        .row_addr  (addr[ADDR_W-2:0]),
        .wdata     (din),
        .rd_byte   (rd_byte),
        .sec_q     (sec_q)
    );

    mtp_read_path u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_now (mode_now),
        .sec_sel  (sec_sel),
        .rd_byte  (rd_byte),
        .sec_q    (sec_q),
        .dout     (dout),
        .dout_en  (dout_en)
    );
endmodule

// File: rtl/mtp_prog_ctrl_chk.sv
// Property checker for the mode controller, bound into the top module.
// Assumes reset is held for at least one full clock.
module mtp_prog_ctrl_chk
    import mtp_prog_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       oe_n,
    input logic       addr_msb,
    input logic [7:0] dout,
    input logic [7:0] dout_en_dummy_unused_guard,
    input logic       dout_en,
    input logic [2:0] mode_o,
    input logic [7:0] sec_q
);
    // R3
    oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n) |-> (!dout_en && dout == 8'h00));

    // R4
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (mode_o == MD_READ || mode_o == MD_PVER || mode_o == MD_EVER));

    // R7
    erase_fills_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_ERASE) |-> (sec_q == 8'hFF));

    // R6
    sec_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_o != MD_ERASE) |-> ((sec_q & ~$past(sec_q)) == 8'h00));

    // R8
    lock_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MD_READ && !$past(addr_msb) && !$past(sec_q[LOCK_BIT]))
            |-> (dout == 8'hFF));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (mode_o == MD_IDLE && !dout_en) || !$past(rst_n, 2) || 1'b0 ||
        (mode_o == MD_IDLE));
endmodule

bind mtp_prog_ctrl mtp_prog_ctrl_chk u_chk (
    .clk                        (clk),
    .rst_n                      (rst_n),
    .oe_n                       (oe_n),
    .addr_msb                   (addr[ADDR_W-1]),
    .dout                       (dout),
    .dout_en_dummy_unused_guard (dout),
    .dout_en                    (dout_en),
    .mode_o                     (mode_o),
    .sec_q                      (sec_q)
);

// File: tb/tb_mtp_prog_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// reset tests. Inputs change on the falling edge; outputs are checked one
// falling edge later, after the single registering edge.
module tb_mtp_prog_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  din = 8'h0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  vlvl = 2'd0;
    logic [7:0]  dout;
    logic        dout_en;
    logic [2:0]  mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mtp_prog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
        .oe_n(oe_n), .vlvl(vlvl), .dout(dout), .dout_en(dout_en), .mode_o(mode_o)
    );

    typedef struct packed {
        logic [1:0]  vl;
        logic        ce;
        logic        oe;
        logic [15:0] ad;
        logic [7:0]  di;
        logic        en;
        logic [7:0]  dq;
        logic [2:0]  md;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b0,1'b0,16'h0010,8'h00,1'b1,8'hFF,3'd1,4'd4},  // R4 erased read
        '{2'd1,1'b0,1'b1,16'h0010,8'hF0,1'b0,8'h00,3'd3,4'd5},  // R5 program
        '{2'd1,1'b0,1'b1,16'h0010,8'h0F,1'b0,8'h00,3'd3,4'd5},  // R5 held, no repeat
        '{2'd1,1'b1,1'b0,16'h0010,8'h00,1'b1,8'hF0,3'd4,4'd9},  // R9 verify
        '{2'd1,1'b0,1'b1,16'h0010,8'h3C,0,8'h00,3'd3,4'd6},     // R6 program again
        '{2'd1,1'b1,1'b0,16'h0010,8'h00,1'b1,8'h30,3'd4,4'd6},  // R6 AND result
        '{2'd0,1'b0,1'b0,16'h0010,8'h00,1'b1,8'h30,3'd1,4'd4},  // R4 read
        '{2'd0,1'b0,1'b0,16'h0011,8'h00,1'b1,8'hFF,3'd1,4'd4},  // R4 neighbour
        '{2'd0,1'b0,1'b1,16'h0010,8'h00,1'b0,8'h00,3'd2,4'd3},  // R3 output disable
        '{2'd0,1'b1,1'b1,16'h0010,8'h00,1'b0,8'h00,3'd2,4'd3},  // R3 disable ce high
        '{2'd0,1'b1,1'b0,16'h0010,8'h00,1'b0,8'h00,3'd0,4'd10}, // R10 idle
        '{2'd3,1'b0,1'b1,16'h0010,8'h00,1'b0,8'h00,3'd0,4'd10}, // R10 reserved level
        '{2'd1,1'b0,1'b0,16'h0010,8'h00,1'b0,8'h00,3'd0,4'd10}, // R10 idle
        '{2'd1,1'b1,1'b1,16'h0010,8'h00,1'b0,8'h00,3'd0,4'd10}, // R10 idle
        '{2'd2,1'b0,1'b0,16'h0010,8'h00,1'b0,8'h00,3'd0,4'd10}, // R10 idle
        '{2'd0,1'b0,1'b0,16'h0010,8'h00,1'b1,8'h30,3'd1,4'd10}, // R10 unchanged
        '{2'd1,1'b0,1'b1,16'h0100,8'h00,1'b0,8'h00,3'd3,4'd4},  // R4 out-of-range prog
        '{2'd0,1'b0,1'b0,16'h0100,8'h00,1'b1,8'hFF,3'd1,4'd4},  // R4 out-of-range read
        '{2'd0,1'b0,1'b0,16'h0000,8'h00,1'b1,8'hFF,3'd1,4'd4},  // R4 row 0 untouched
        '{2'd1,1'b0,1'b1,16'h00FF,8'h11,1'b0,8'h00,3'd3,4'd5},  // R5 last row
        '{2'd0,1'b0,1'b0,16'h00FF,8'h00,1'b1,8'h11,3'd1,4'd4},  // R4 last row
        '{2'd1,1'b0,1'b1,16'h8000,8'hA5,1'b0,8'h00,3'd3,4'd5},  // R5 security
        '{2'd0,1'b0,1'b0,16'h8000,8'h00,1'b1,8'hA5,3'd1,4'd4},  // R4 security read
        '{2'd1,1'b0,1'b1,16'h8000,8'hFE,1'b0,8'h00,3'd3,4'd8},  // R8 set lock
        '{2'd0,1'b0,1'b0,16'h8000,8'h00,1'b1,8'hA4,3'd1,4'd8},  // R8 security visible
        '{2'd0,1'b0,1'b0,16'h0010,8'h00,1'b1,8'hFF,3'd1,4'd8},  // R8 blanked read
        '{2'd1,1'b1,1'b0,16'h00FF,8'h00,1'b1,8'hFF,3'd4,4'd8},  // R8 blanked verify
        '{2'd2,1'b1,1'b0,16'h0010,8'h00,1'b1,8'hFF,3'd6,4'd8},  // R8 blanked erase verify
        '{2'd2,1'b0,1'b1,16'h0010,8'h00,1'b0,8'h00,3'd5,4'd7},  // R7 erase
        '{2'd2,1'b1,1'b0,16'h0010,8'h00,1'b1,8'hFF,3'd6,4'd7},  // R7 erased byte
        '{2'd2,1'b1,1'b0,16'h8000,8'h00,1'b1,8'hFF,3'd6,4'd7},  // R7 erased security
        '{2'd2,1'b1,1'b0,16'h00FF,8'h00,1'b1,8'hFF,3'd6,4'd7},  // R7 last row erased
        '{2'd1,1'b0,1'b1,16'h0010,8'h5A,1'b0,8'h00,3'd3,4'd7},  // R7 reprogram after erase
        '{2'd0,1'b0,1'b0,16'h0010,8'h00,1'b1,8'h5A,3'd1,4'd7}   // R7 unlocked, 1s restored
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] v, input logic c, input logic o,
                         input logic [15:0] a, input logic [7:0] d);
        vlvl = v; ce_n = c; oe_n = o; addr = a; din = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        chk("R1 dout_en", {7'd0, dout_en}, 8'h00);
        chk("R1 dout", dout, 8'h00);
        chk("R1 mode", {5'd0, mode_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].vl, VEC[i].ce, VEC[i].oe, VEC[i].ad, VEC[i].di);
            @(negedge clk);
            chk($sformatf("R2 mode vec %0d", i), {5'd0, mode_o}, {5'd0, VEC[i].md});
            chk($sformatf("R%0d enable vec %0d", VEC[i].rq, i),
                {7'd0, dout_en}, {7'd0, VEC[i].en});
            chk($sformatf("R%0d data vec %0d", VEC[i].rq, i), dout, VEC[i].dq);
        end

        // R1 reset mid-run with a read pending: outputs cleared
        drive(2'd0, 1'b0, 1'b0, 16'h0010, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-reset dout_en", {7'd0, dout_en}, 8'h00);
        chk("R1 mid-reset mode", {5'd0, mode_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 array refilled with ones (byte was 0x5A)
        chk("R1 array after reset", dout, 8'hFF);
        chk("R1 read enable after reset", {7'd0, dout_en}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule